// File: doc/BRIEF.md
# Reorder Buffer Pointer and Rename Control

This block is the in-order bookkeeping core of an out-of-order issue engine. It owns a circular reorder buffer addressed by a head pointer (oldest live entry) and a tail pointer (next free entry), plus an occupancy counter one bit wider than the pointers, so a full buffer and an empty buffer read differently. Each accepted issue takes the tail slot. The slot's index becomes the instruction's tag.

On issue, the slot records the destination register, two "next" program-counter values and the two program-counter values in force before the instruction. If the result is already known at issue time, the slot is marked complete with that result. If not, it is marked pending, and a later completion strobe carrying the tag fills it in. The same issue also retags the destination register in a register status table (valid bit plus producer tag) and loads the chosen reservation-station slot with the new tag.

A writeback strobe retires the head entry once it is complete. The retiring entry is presented on the head port. A register whose producer tag still names the retiring entry becomes valid again.

Top module: `rob_rename_ctrl`

## Requirements
- R1: A synchronous active-high reset empties the buffer (occupancy 0, head not valid), marks every register valid and every reservation-station slot not valid.
- R2: Issue is accepted (`iss_ok`) when `iss_req` is high and occupancy is below the depth, even if a writeback happens in the same cycle. The assigned tag `iss_tag` equals the tail pointer, which then advances by one modulo the depth. A refused issue changes nothing.
- R3: Occupancy rises by one for an accepted issue without a writeback, falls by one for a writeback without an issue, and holds when both or neither occur.
- R4: An accepted issue with `iss_done` high marks the tail entry complete with `iss_result`. With `iss_done` low, the entry is marked pending and its stored result field keeps its former value, which `head_result` shows while that entry is at the head.
- R5: A completion strobe (`cmp_req`) marks the entry named by `cmp_tag` complete and stores `cmp_result`.
- R6: An accepted issue with `iss_has_dest` high clears the valid bit of register `iss_dest` and writes the assigned tag into its tag field. Without a destination, the register table is left untouched.
- R7: An accepted issue sets reservation-station slot `iss_rs` valid with the assigned tag. A bit of `rs_clr` frees its slot, but an issue to the same slot in the same cycle wins.
- R8: Writeback is accepted (`wb_ok`) only when `wb_req` is high, occupancy is nonzero and the head entry is complete. An accepted writeback advances the head pointer by one.
- R9: On an accepted writeback, a register becomes valid again only if its stored tag equals the retiring head tag. An issue retagging the same register in that cycle takes priority.
- R10: The head port presents the destination flag and address and the four program-counter values that were recorded when the head entry was issued.
- R11: Occupancy is one bit wider than the tag and reaches exactly the depth when the buffer is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_req | input | 1 | Issue request |
| iss_has_dest | input | 1 | Instruction writes a register |
| iss_dest | input | REG_W | Destination register index |
| iss_rs | input | RS_W | Reservation-station slot to load |
| iss_done | input | 1 | Result already known at issue |
| iss_result | input | DATA_W | Result value when known at issue |
| iss_next_pc | input | PC_W | Next fetch PC after the instruction |
| iss_next_dpc | input | PC_W | Next delayed PC after the instruction |
| iss_cur_pc | input | PC_W | Fetch PC in force before the instruction |
| iss_cur_dpc | input | PC_W | Delayed PC in force before the instruction |
| iss_ok | output | 1 | Issue accepted this cycle |
| iss_tag | output | TAG_W | Tag assigned to the issuing instruction |
| cmp_req | input | 1 | Completion strobe |
| cmp_tag | input | TAG_W | Entry being completed |
| cmp_result | input | DATA_W | Completed result |
| rs_clr | input | NRS | Per-slot reservation-station release |
| wb_req | input | 1 | Writeback request |
| wb_ok | output | 1 | Writeback accepted this cycle |
| head_valid | output | 1 | Head entry is live and complete |
| head_tag | output | TAG_W | Head pointer |
| head_result | output | DATA_W | Stored result of head entry |
| head_has_dest | output | 1 | Head entry writes a register |
| head_dest | output | REG_W | Head entry destination |
| head_next_pc | output | PC_W | Recorded next fetch PC |
| head_next_dpc | output | PC_W | Recorded next delayed PC |
| head_cur_pc | output | PC_W | Recorded prior fetch PC |
| head_cur_dpc | output | PC_W | Recorded prior delayed PC |
| occupancy | output | TAG_W+1 | Number of live entries |
| reg_valid | output | NREG | Per-register valid bit |
| reg_tag | output | NREG x TAG_W | Per-register producer tag |
| rs_valid | output | NRS | Per-slot valid bit |
| rs_tag | output | NRS x TAG_W | Per-slot tag |

## Verification
Issue and writeback can fall in the same cycle, and then the counter must hold while both pointers move. When the issuing instruction targets the register that the retiring entry last produced, the new tag must survive the release. The bench drives both strobes in one cycle with that register overlap, and also with a reservation-station release on the slot being loaded. It judges the result from the occupancy, the register tag and valid bit, and the slot tag. A further case drives both strobes while the buffer is full, where the issue must still be refused.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_INC  = 2'd1,
        CNT_DEC  = 2'd2
    } cnt_op_e;

    function automatic cnt_op_e cnt_op(input logic up, input logic down);
        if (up && !down)      return CNT_INC;
        else if (down && !up) return CNT_DEC;
        else                  return CNT_HOLD;
    endfunction

endpackage

// File: rtl/rob_ptr_ctl.sv
module rob_ptr_ctl
    import rob_pkg::*;
#(
    parameter int TAG_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             iss_req,
    input  logic             wb_req,
    input  logic             head_rdy,
    output logic             iss_ok,
    output logic             wb_ok,
    output logic [TAG_W-1:0] head,
    output logic [TAG_W-1:0] tail,
    output logic [TAG_W:0]   count
);
    localparam int DEPTH = 1 << TAG_W;
    localparam int CNT_W = TAG_W + 1;

    logic full_q;
    logic empty_q;

    assign full_q  = (count == CNT_W'(DEPTH));
    assign empty_q = (count == '0);
    assign iss_ok  = iss_req && !full_q;
    assign wb_ok   = wb_req && head_rdy && !empty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (iss_ok) tail <= tail + 1'b1;
            if (wb_ok)  head <= head + 1'b1;
            unique case (cnt_op(iss_ok, wb_ok))
                CNT_INC: count <= count + 1'b1;
                CNT_DEC: count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/rob_entry_store.sv
module rob_entry_store #(
    parameter int TAG_W  = 3,
    parameter int REG_W  = 3,
    parameter int DATA_W = 32,
    parameter int PC_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_we,
    input  logic [TAG_W-1:0]  iss_idx,
    input  logic              iss_done,
    input  logic [DATA_W-1:0] iss_result,
    input  logic              iss_has_dest,
    input  logic [REG_W-1:0]  iss_dest,
    input  logic [PC_W-1:0]   iss_next_pc,
    input  logic [PC_W-1:0]   iss_next_dpc,
    input  logic [PC_W-1:0]   iss_cur_pc,
    input  logic [PC_W-1:0]   iss_cur_dpc,
    input  logic              cmp_we,
    input  logic [TAG_W-1:0]  cmp_idx,
    input  logic [DATA_W-1:0] cmp_result,
    input  logic [TAG_W-1:0]  head_idx,
    output logic              head_done,
    output logic [DATA_W-1:0] head_result,
    output logic              head_has_dest,
    output logic [REG_W-1:0]  head_dest,
    output logic [PC_W-1:0]   head_next_pc,
    output logic [PC_W-1:0]   head_next_dpc,
    output logic [PC_W-1:0]   head_cur_pc,
    output logic [PC_W-1:0]   head_cur_dpc
);
    localparam int DEPTH = 1 << TAG_W;

    typedef struct packed {
        logic             has_dest;
        logic [REG_W-1:0] dest;
        logic [PC_W-1:0]  next_pc;
        logic [PC_W-1:0]  next_dpc;
        logic [PC_W-1:0]  cur_pc;
        logic [PC_W-1:0]  cur_dpc;
    } meta_t;

    logic [DEPTH-1:0]  done_q;
    logic [DATA_W-1:0] res_q  [DEPTH];
    meta_t             meta_q [DEPTH];
    logic              cmp_live;
    meta_t             head_meta;

    // an issue into the same slot overrides a completion aimed at it
    assign cmp_live = cmp_we && !(iss_we && (cmp_idx == iss_idx));

    for (genvar e = 0; e < DEPTH; e++) begin : g_done
        always_ff @(posedge clk) begin
            if (rst)
                done_q[e] <= 1'b0;
            else if (iss_we && (iss_idx == TAG_W'(e)))
                done_q[e] <= iss_done;
            else if (cmp_live && (cmp_idx == TAG_W'(e)))
                done_q[e] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (iss_we) begin
            meta_q[iss_idx] <= '{has_dest: iss_has_dest, dest: iss_dest,
                                 next_pc: iss_next_pc, next_dpc: iss_next_dpc,
                                 cur_pc: iss_cur_pc, cur_dpc: iss_cur_dpc};
            if (iss_done) res_q[iss_idx] <= iss_result;
        end
        if (cmp_live) res_q[cmp_idx] <= cmp_result;
    end

    assign head_meta     = meta_q[head_idx];
    assign head_done     = done_q[head_idx];
    assign head_result   = res_q[head_idx];
    assign head_has_dest = head_meta.has_dest;
    assign head_dest     = head_meta.dest;
    assign head_next_pc  = head_meta.next_pc;
    assign head_next_dpc = head_meta.next_dpc;
    assign head_cur_pc   = head_meta.cur_pc;
    assign head_cur_dpc  = head_meta.cur_dpc;
endmodule

// File: rtl/rob_reg_status.sv
module rob_reg_status #(
    parameter int NREG  = 8,
    parameter int TAG_W = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        set_en,
    input  logic [$clog2(NREG)-1:0]     set_reg,
    input  logic [TAG_W-1:0]            set_tag,
    input  logic                        rel_en,
    input  logic [TAG_W-1:0]            rel_tag,
    output logic [NREG-1:0]             valid,
    output logic [NREG-1:0][TAG_W-1:0]  tag
);
    localparam int REG_W = $clog2(NREG);

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        logic hit_set;
        logic hit_rel;
        assign hit_set = set_en && (set_reg == REG_W'(r));
        assign hit_rel = rel_en && (tag[r] == rel_tag);

        always_ff @(posedge clk) begin
            if (rst) begin
                valid[r] <= 1'b1;
                tag[r]   <= '0;
            end else if (hit_set) begin
                valid[r] <= 1'b0;
                tag[r]   <= set_tag;
            end else if (hit_rel) begin
                valid[r] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rob_rs_slots.sv
module rob_rs_slots #(
    parameter int NRS   = 4,
    parameter int TAG_W = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load_en,
    input  logic [$clog2(NRS)-1:0]     load_slot,
    input  logic [TAG_W-1:0]           load_tag,
    input  logic [NRS-1:0]             clr,
    output logic [NRS-1:0]             valid,
    output logic [NRS-1:0][TAG_W-1:0]  tag
);
    localparam int RS_W = $clog2(NRS);

    for (genvar s = 0; s < NRS; s++) begin : g_slot
        logic hit;
        assign hit = load_en && (load_slot == RS_W'(s));

        always_ff @(posedge clk) begin
            if (rst) begin
                valid[s] <= 1'b0;
                tag[s]   <= '0;
            end else if (hit) begin
                valid[s] <= 1'b1;
                tag[s]   <= load_tag;
            end else if (clr[s]) begin
                valid[s] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rob_rename_ctrl.sv
module rob_rename_ctrl #(
    parameter int TAG_W  = 3,
    parameter int NREG   = 8,
    parameter int NRS    = 4,
    parameter int DATA_W = 32,
    parameter int PC_W   = 32,
    localparam int REG_W = $clog2(NREG),
    localparam int RS_W  = $clog2(NRS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       iss_req,
    input  logic                       iss_has_dest,
    input  logic [REG_W-1:0]           iss_dest,
    input  logic [RS_W-1:0]            iss_rs,
    input  logic                       iss_done,
    input  logic [DATA_W-1:0]          iss_result,
    input  logic [PC_W-1:0]            iss_next_pc,
    input  logic [PC_W-1:0]            iss_next_dpc,
    input  logic [PC_W-1:0]            iss_cur_pc,
    input  logic [PC_W-1:0]            iss_cur_dpc,
    output logic                       iss_ok,
    output logic [TAG_W-1:0]           iss_tag,
    input  logic                       cmp_req,
    input  logic [TAG_W-1:0]           cmp_tag,
    input  logic [DATA_W-1:0]          cmp_result,
    input  logic [NRS-1:0]             rs_clr,
    input  logic                       wb_req,
    output logic                       wb_ok,
    output logic                       head_valid,
    output logic [TAG_W-1:0]           head_tag,
    output logic [DATA_W-1:0]          head_result,
    output logic                       head_has_dest,
    output logic [REG_W-1:0]           head_dest,
    output logic [PC_W-1:0]            head_next_pc,
    output logic [PC_W-1:0]            head_next_dpc,
    output logic [PC_W-1:0]            head_cur_pc,
    output logic [PC_W-1:0]            head_cur_dpc,
    output logic [TAG_W:0]             occupancy,
    output logic [NREG-1:0]            reg_valid,
    output logic [NREG-1:0][TAG_W-1:0] reg_tag,
    output logic [NRS-1:0]             rs_valid,
    output logic [NRS-1:0][TAG_W-1:0]  rs_tag
);
    logic [TAG_W-1:0] head_q;
    logic [TAG_W-1:0] tail_q;
    logic             head_done;

    rob_ptr_ctl #(.TAG_W(TAG_W)) u_ptr (
        .clk(clk), .rst(rst),
        .iss_req(iss_req), .wb_req(wb_req), .head_rdy(head_done),
        .iss_ok(iss_ok), .wb_ok(wb_ok),
        .head(head_q), .tail(tail_q), .count(occupancy)
    );

    rob_entry_store #(.TAG_W(TAG_W), .REG_W(REG_W), .DATA_W(DATA_W), .PC_W(PC_W)) u_store (
        .clk(clk), .rst(rst),
        .iss_we(iss_ok), .iss_idx(tail_q), .iss_done(iss_done), .iss_result(iss_result),
        .iss_has_dest(iss_has_dest), .iss_dest(iss_dest),
        .iss_next_pc(iss_next_pc), .iss_next_dpc(iss_next_dpc),
        .iss_cur_pc(iss_cur_pc), .iss_cur_dpc(iss_cur_dpc),
        .cmp_we(cmp_req), .cmp_idx(cmp_tag), .cmp_result(cmp_result),
        .head_idx(head_q), .head_done(head_done), .head_result(head_result),
        .head_has_dest(head_has_dest), .head_dest(head_dest),
        .head_next_pc(head_next_pc), .head_next_dpc(head_next_dpc),
        .head_cur_pc(head_cur_pc), .head_cur_dpc(head_cur_dpc)
    );

    rob_reg_status #(.NREG(NREG), .TAG_W(TAG_W)) u_regs (
        .clk(clk), .rst(rst),
        .set_en(iss_ok && iss_has_dest), .set_reg(iss_dest), .set_tag(tail_q),
        .rel_en(wb_ok), .rel_tag(head_q),
        .valid(reg_valid), .tag(reg_tag)
    );

    rob_rs_slots #(.NRS(NRS), .TAG_W(TAG_W)) u_rs (
        .clk(clk), .rst(rst),
        .load_en(iss_ok), .load_slot(iss_rs), .load_tag(tail_q),
        .clr(rs_clr), .valid(rs_valid), .tag(rs_tag)
    );

    assign iss_tag    = tail_q;
    assign head_tag   = head_q;
    assign head_valid = head_done && (occupancy != '0);
endmodule

// File: rtl/rob_rename_ctrl_chk.sv
module rob_rename_ctrl_chk #(
    parameter int TAG_W = 3,
    parameter int NREG  = 8,
    parameter int NRS   = 4,
    localparam int REG_W = $clog2(NREG),
    localparam int RS_W  = $clog2(NRS)
) (
    input logic             clk,
    input logic             rst,
    input logic             iss_ok,
    input logic             iss_has_dest,
    input logic [REG_W-1:0] iss_dest,
    input logic [RS_W-1:0]  iss_rs,
    input logic [TAG_W-1:0] iss_tag,
    input logic             wb_ok,
    input logic [TAG_W-1:0] head_tag,
    input logic [TAG_W:0]   occupancy,
    input logic [NREG-1:0]  reg_valid,
    input logic [NRS-1:0]   rs_valid
);
    localparam int DEPTH = 1 << TAG_W;

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        occupancy <= (TAG_W+1)'(DEPTH));

    // R2
    full_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (occupancy == (TAG_W+1)'(DEPTH)) |-> !iss_ok);

    // R2
    tail_step_chk: assert property (@(posedge clk) disable iff (rst)
        iss_ok |=> (iss_tag == $past(iss_tag) + 1'b1));

    // R3
    count_up_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_ok && !wb_ok) |=> (occupancy == $past(occupancy) + 1'b1));

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_ok == wb_ok) |=> $stable(occupancy));

    // R8
    wb_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        wb_ok |-> (occupancy != '0));

    // R8
    head_step_chk: assert property (@(posedge clk) disable iff (rst)
        wb_ok |=> (head_tag == $past(head_tag) + 1'b1));

    // R6
    dest_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_ok && iss_has_dest) |=> !reg_valid[$past(iss_dest)]);

    // R7
    rs_load_chk: assert property (@(posedge clk) disable iff (rst)
        iss_ok |=> rs_valid[$past(iss_rs)]);
endmodule

bind rob_rename_ctrl rob_rename_ctrl_chk #(.TAG_W(TAG_W), .NREG(NREG), .NRS(NRS)) u_chk (
    .clk(clk), .rst(rst), .iss_ok(iss_ok), .iss_has_dest(iss_has_dest),
    .iss_dest(iss_dest), .iss_rs(iss_rs), .iss_tag(iss_tag), .wb_ok(wb_ok),
    .head_tag(head_tag), .occupancy(occupancy), .reg_valid(reg_valid), .rs_valid(rs_valid)
);

// File: tb/rob_rename_ctrl_bench.sv
`timescale 1ns/1ps
module rob_rename_ctrl_bench;
    localparam int TAG_W = 3;
    localparam int NREG  = 8;
    localparam int NRS   = 4;
    localparam int DW    = 32;
    localparam int DEPTH = 1 << TAG_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic                       iss_req = 0, iss_has_dest = 0, iss_done = 0;
    logic [2:0]                 iss_dest = 0;
    logic [1:0]                 iss_rs = 0;
    logic [DW-1:0]              iss_result = 0, iss_next_pc = 0, iss_next_dpc = 0, iss_cur_pc = 0, iss_cur_dpc = 0;
    logic                       iss_ok;
    logic [TAG_W-1:0]           iss_tag;
    logic                       cmp_req = 0;
    logic [TAG_W-1:0]           cmp_tag = 0;
    logic [DW-1:0]              cmp_result = 0;
    logic [NRS-1:0]             rs_clr = 0;
    logic                       wb_req = 0, wb_ok, head_valid, head_has_dest;
    logic [TAG_W-1:0]           head_tag;
    logic [DW-1:0]              head_result, head_next_pc, head_next_dpc, head_cur_pc, head_cur_dpc;
    logic [2:0]                 head_dest;
    logic [TAG_W:0]             occupancy;
    logic [NREG-1:0]            reg_valid;
    logic [NREG-1:0][TAG_W-1:0] reg_tag;
    logic [NRS-1:0]             rs_valid;
    logic [NRS-1:0][TAG_W-1:0]  rs_tag;

    rob_rename_ctrl u_rob_rename_ctrl (
        .clk(clk), .rst(rst), .iss_req(iss_req), .iss_has_dest(iss_has_dest), .iss_dest(iss_dest),
        .iss_rs(iss_rs), .iss_done(iss_done), .iss_result(iss_result), .iss_next_pc(iss_next_pc),
        .iss_next_dpc(iss_next_dpc), .iss_cur_pc(iss_cur_pc), .iss_cur_dpc(iss_cur_dpc),
        .iss_ok(iss_ok), .iss_tag(iss_tag), .cmp_req(cmp_req), .cmp_tag(cmp_tag),
        .cmp_result(cmp_result), .rs_clr(rs_clr), .wb_req(wb_req), .wb_ok(wb_ok),
        .head_valid(head_valid), .head_tag(head_tag), .head_result(head_result),
        .head_has_dest(head_has_dest), .head_dest(head_dest), .head_next_pc(head_next_pc),
        .head_next_dpc(head_next_dpc), .head_cur_pc(head_cur_pc), .head_cur_dpc(head_cur_dpc),
        .occupancy(occupancy), .reg_valid(reg_valid), .reg_tag(reg_tag),
        .rs_valid(rs_valid), .rs_tag(rs_tag)
    );

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference model, built from the requirements
    typedef struct {
        logic [TAG_W-1:0] tag;
        bit               hd;
        logic [2:0]       dst;
        logic [DW-1:0]    seed;
    } item_t;
    item_t            sb_q[$];
    int               m_count = 0;
    logic [TAG_W-1:0] m_head = 0, m_tail = 0;
    logic [DW-1:0]    m_res[DEPTH];
    bit               m_rdy[DEPTH];

    // one cycle of stimulus: drive at the falling edge, judge the strobes, update the model after the rising edge
    task automatic step(input bit ir, input bit hd, input int dst, input int rs, input bit dn,
                        input logic [DW-1:0] res, input bit wr, input bit cr, input int ct,
                        input logic [DW-1:0] cd, input logic [NRS-1:0] clr);
        bit e_iok, e_wok;
        logic [TAG_W-1:0] t;
        @(negedge clk);
        iss_req = ir; iss_has_dest = hd; iss_dest = 3'(dst); iss_rs = 2'(rs); iss_done = dn;
        iss_result = res; iss_next_pc = res + 1; iss_next_dpc = res + 2;
        iss_cur_pc = res + 3; iss_cur_dpc = res + 4;
        wb_req = wr; cmp_req = cr; cmp_tag = TAG_W'(ct); cmp_result = cd; rs_clr = clr;
        #1;
        e_iok = ir && (m_count != DEPTH);
        e_wok = wr && (m_count != 0) && m_rdy[m_head];
        chk(iss_ok == e_iok, "R2 issue accept", 64'(iss_ok), 64'(e_iok));
        if (e_iok) begin
            chk(iss_tag == m_tail, "R2 issue tag", 64'(iss_tag), 64'(m_tail));
            sb_q.push_back('{tag: m_tail, hd: hd, dst: 3'(dst), seed: res});
        end
        chk(wb_ok == e_wok, "R8 writeback accept", 64'(wb_ok), 64'(e_wok));
        @(posedge clk);
        if (cr) begin m_rdy[ct] = 1; m_res[ct] = cd; end
        if (e_iok) begin
            t = m_tail;
            m_rdy[t] = dn;
            if (dn) m_res[t] = res;
            m_tail = m_tail + 1'b1;
        end
        if (e_wok) m_head = m_head + 1'b1;
        m_count = m_count + (e_iok ? 1 : 0) - (e_wok ? 1 : 0);
        #1;
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, '0);
    endtask

    // monitor: each accepted writeback must retire the oldest expected entry
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst && wb_ok) begin
                if (sb_q.size() == 0) begin
                    chk(0, "R8 retire with no expected entry", 64'(head_tag), 64'hffff);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    chk(head_tag == it.tag, "R8 retire order", 64'(head_tag), 64'(it.tag));
                    chk(head_result == m_res[it.tag], "R5 retire result", 64'(head_result), 64'(m_res[it.tag]));
                    chk(head_has_dest == it.hd, "R10 dest flag", 64'(head_has_dest), 64'(it.hd));
                    if (it.hd) chk(head_dest == it.dst, "R10 dest", 64'(head_dest), 64'(it.dst));
                    chk(head_next_pc == it.seed + 1, "R10 next pc", 64'(head_next_pc), 64'(it.seed + 1));
                    chk(head_next_dpc == it.seed + 2, "R10 next dpc", 64'(head_next_dpc), 64'(it.seed + 2));
                    chk(head_cur_pc == it.seed + 3, "R10 cur pc", 64'(head_cur_pc), 64'(it.seed + 3));
                    chk(head_cur_dpc == it.seed + 4, "R10 cur dpc", 64'(head_cur_dpc), 64'(it.seed + 4));
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin m_res[i] = '0; m_rdy[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1
        chk(occupancy == 0, "R1 occupancy", 64'(occupancy), 0);
        chk(head_valid == 0, "R1 head valid", 64'(head_valid), 0);
        chk(reg_valid == '1, "R1 registers valid", 64'(reg_valid), 64'hff);
        chk(rs_valid == '0, "R1 slots free", 64'(rs_valid), 0);

        // R4 complete at issue, R6 and R7 retag
        step(1, 1, 1, 0, 1, 32'h11, 0, 0, 0, 0, '0);
        chk(occupancy == 1, "R3 rise", 64'(occupancy), 1);
        chk(reg_valid[1] == 0 && reg_tag[1] == 0, "R6 dest retag", 64'({reg_valid[1], reg_tag[1]}), 0);
        chk(rs_valid[0] && rs_tag[0] == 0, "R7 slot load", 64'({rs_valid[0], rs_tag[0]}), 64'h8);
        chk(head_valid == 1 && head_result == 32'h11, "R4 ready at issue", 64'(head_result), 64'h11);

        step(1, 1, 2, 1, 0, 32'h22, 0, 0, 0, 0, '0);
        chk(reg_tag[2] == 1 && rs_tag[1] == 1, "R6 second tag", 64'({reg_tag[2], rs_tag[1]}), 64'h9);
        step(1, 0, 5, 2, 1, 32'h33, 0, 0, 0, 0, '0);
        chk(reg_valid == 8'hF9, "R6 no-dest leaves table", 64'(reg_valid), 64'hF9);

        step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, '0);
        chk(reg_valid[1] == 1, "R9 matching release", 64'(reg_valid[1]), 1);
        chk(occupancy == 2, "R3 fall", 64'(occupancy), 2);

        // R8 head pending: refused
        step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, '0);
        chk(occupancy == 2 && head_valid == 0, "R8 pending head held", 64'(occupancy), 2);

        // R5 completion
        step(0, 0, 0, 0, 0, 0, 0, 1, 1, 32'h2222, '0);
        chk(head_valid == 1 && head_result == 32'h2222, "R5 completion", 64'(head_result), 64'h2222);

        // same-cycle issue and writeback, same register, slot load vs release
        step(1, 1, 2, 1, 1, 32'h44, 1, 0, 0, 0, 4'b0011);
        chk(occupancy == 2, "R3 hold on both", 64'(occupancy), 2);
        chk(reg_valid[2] == 0 && reg_tag[2] == 3, "R9 issue beats release", 64'({reg_valid[2], reg_tag[2]}), 64'h3);
        chk(rs_valid[1] && rs_tag[1] == 3, "R7 load beats clear", 64'({rs_valid[1], rs_tag[1]}), 64'hB);
        chk(rs_valid[0] == 0, "R7 clear", 64'(rs_valid[0]), 0);

        // fill to the depth
        for (int k = 0; k < 6; k++) step(1, 0, 0, 3, 1, 32'h100 + k, 0, 0, 0, 0, '0);
        chk(occupancy == DEPTH, "R11 full count", 64'(occupancy), DEPTH);
        step(1, 1, 6, 0, 1, 32'h77, 0, 0, 0, 0, '0);
        chk(occupancy == DEPTH && reg_valid[6] == 1, "R2 refused issue no effect", 64'(occupancy), DEPTH);
        step(1, 1, 6, 0, 1, 32'h78, 1, 0, 0, 0, '0);
        chk(occupancy == DEPTH - 1, "R2 full refuse with writeback", 64'(occupancy), DEPTH - 1);

        // drain
        for (int k = 0; k < DEPTH - 1; k++) step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, '0);
        chk(occupancy == 0 && head_valid == 0, "R8 drained", 64'(occupancy), 0);
        chk(reg_valid == '1, "R9 all released", 64'(reg_valid), 64'hff);
        step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, '0);
        chk(occupancy == 0, "R8 empty writeback refused", 64'(occupancy), 0);

        // R4 pending entry keeps old result field
        step(1, 1, 4, 2, 0, 32'h55, 0, 0, 0, 0, '0);
        chk(head_valid == 0, "R4 pending at issue", 64'(head_valid), 0);
        chk(head_result == m_res[head_tag], "R4 old result kept", 64'(head_result), 64'(m_res[head_tag]));
        chk(head_result == 32'h33, "R4 old value", 64'(head_result), 64'h33);
        step(0, 0, 0, 0, 0, 0, 0, 1, int'(head_tag), 32'h5555, '0);
        step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, '0);
        chk(occupancy == 0 && reg_valid[4] == 1, "R9 final release", 64'(occupancy), 0);
        idle();
        chk(sb_q.size() == 0, "R8 scoreboard drained", 64'(sb_q.size()), 0);

        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule